// File: doc/BRIEF.md
# Software Store Key Detector

This block sits beside a battery-free memory array and watches the read and write accesses presented to it. A store of the array into its nonvolatile copy is requested by software through a read-only key: six enable-controlled reads of fixed addresses, back to back, with no other access in between. When the sixth key read completes, the block runs a store cycle. The cycle has an erase phase of a set number of clocks, then a program phase of a set number of clocks. While the store runs, all array reads and writes are held off.

Each access reaches the block as a one-cycle `accValid` pulse, which marks the end of a memory cycle. The pulse carries the address, a write flag and a flag that says whether the chip enable terminated the cycle. The block passes accesses on to the array as read and write strobes, and it drops them while a store is busy. A read that does not match the key breaks the sequence. A write also breaks it, and the write itself still reaches the array. A read of the first key address re-arms the detector straight away.

Top module: `store_key_detector`

## Requirements
- R1: The key is six reads with `accWrite`=0 and `accCeCtl`=1 of addresses 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0, 0x0F0F, in that order. `keyStep` counts the matched reads (0 to 5). `storeBusy` and `erasePhase` are high in the cycle after the `accValid` of the sixth read.
- R2: A store is `ERASE_CYCLES` cycles with `erasePhase` high, followed by `PROG_CYCLES` cycles with `programPhase` high. The two phases are never high together.
- R3: `storeBusy` stays high for exactly `ERASE_CYCLES + PROG_CYCLES` cycles. `storeDone` is high in the last of those cycles only.
- R4: A key-mode read whose address is neither the expected key nor 0x0000 returns `keyStep` to 0. A sequence broken this way never starts a store.
- R5: A write during a partial sequence returns `keyStep` to 0. `arrayWrStb` is still asserted for that write.
- R6: After a mismatch, a read of 0x0000 sets `keyStep` to 1, and the rest of the key then starts a store.
- R7: A read with `accCeCtl`=0 sets `keyStep` to 0, even if its address is 0x0000.
- R8: While `storeBusy` is high, `arrayRdStb` and `arrayWrStb` stay low and `memDisable` is high. When idle, the strobes follow `accValid`.
- R9: Accesses made while busy are ignored. `keyStep` is 0 when the store ends, so key reads made during a store do not count toward the next one.
- R10: After reset, `storeBusy`, both phase outputs, `storeDone` and `keyStep` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| accValid | input | 1 | One-cycle pulse marking the end of an access |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accCeCtl | input | 1 | 1 when the chip enable terminated the cycle |
| accAddr | input | ADDR_W | Access address |
| arrayRdStb | output | 1 | Read strobe passed on to the array |
| arrayWrStb | output | 1 | Write strobe passed on to the array |
| memDisable | output | 1 | Array input and output blocked |
| storeBusy | output | 1 | Store cycle in progress |
| erasePhase | output | 1 | Erase phase active |
| programPhase | output | 1 | Program phase active |
| storeDone | output | 1 | Last cycle of the store |
| keyStep | output | 3 | Number of key reads matched so far |

## Verification
The array strobes are combinational, so the bench samples them one nanosecond after it drives an access, in the same cycle. `keyStep` and `storeBusy` are registered once, so the bench reads them at the falling edge after the edge that took the access. From that falling edge the bench expects exactly `ERASE_CYCLES` erase samples and then `PROG_CYCLES` program samples, with `storeDone` in the final one and `storeBusy` low at the next falling edge. Every check samples at a falling edge, or 1 ns after one, so no check depends on the order of processes at the rising edge.

// File: rtl/store_key_pkg.sv
package store_key_pkg;
  localparam int KEY_W   = 13;
  localparam int KEY_LEN = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_ERASE, PH_PROG} phase_t;

  typedef struct packed {
    logic loadErase;
    logic loadProg;
    logic tick;
  } timer_ctl_t;

  function automatic logic [KEY_W-1:0] keyAddr(input logic [2:0] idx);
    case (idx)
      3'd0:    keyAddr = 13'h0000;
      3'd1:    keyAddr = 13'h1555;
      3'd2:    keyAddr = 13'h0AAA;
      3'd3:    keyAddr = 13'h1FFF;
      3'd4:    keyAddr = 13'h10F0;
      default: keyAddr = 13'h0F0F;
    endcase
  endfunction
endpackage

// File: rtl/store_key_datapath.sv
module store_key_datapath
  import store_key_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int ERASE_CYCLES = 16,
  parameter int PROG_CYCLES  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [2:0]        stepIdx,
  input  timer_ctl_t        timerCtl,
  output logic              keyHit,
  output logic              firstHit,
  output logic              cntZero
);
  localparam int MAX_CYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] phaseCnt;

  // Address compare against the expected key and the first key
  assign keyHit   = (accAddr == ADDR_W'(keyAddr(stepIdx)));
  assign firstHit = (accAddr == ADDR_W'(keyAddr(3'd0)));
  assign cntZero  = (phaseCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   phaseCnt <= '0;
    else if (timerCtl.loadErase) phaseCnt <= CNT_W'(ERASE_CYCLES - 1);
    else if (timerCtl.loadProg)  phaseCnt <= CNT_W'(PROG_CYCLES - 1);
    else if (timerCtl.tick)      phaseCnt <= phaseCnt - 1'b1;
  end

  AST_NO_LOAD_CLASH: assert property (@(posedge clk) disable iff (!rstN)
    !(timerCtl.loadErase && timerCtl.loadProg)) else $error("load clash"); // R2
  AST_TICK_NOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    timerCtl.tick |-> !cntZero) else $error("counter underflow"); // R3
endmodule

// File: rtl/store_key_control.sv
module store_key_control
  import store_key_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       accCeCtl,
  input  logic       keyHit,
  input  logic       firstHit,
  input  logic       cntZero,
  output timer_ctl_t timerCtl,
  output logic [2:0] stepIdx,
  output logic       busy,
  output logic       inErase,
  output logic       inProg,
  output logic       doneNow
);
  phase_t phase, phaseNext;
  logic [2:0] stepNext;
  logic startReq;
  logic liveAcc;

  assign liveAcc  = accValid && (phase == PH_IDLE);
  assign startReq = liveAcc && !accWrite && accCeCtl && keyHit
                    && (stepIdx == 3'(KEY_LEN - 1));

  // Key sequence tracking
  always_comb begin
    stepNext = stepIdx;
    if (liveAcc) begin
      if (accWrite || !accCeCtl)  stepNext = 3'd0;
      else if (keyHit)            stepNext = startReq ? 3'd0 : stepIdx + 3'd1;
      else if (firstHit)          stepNext = 3'd1;
      else                        stepNext = 3'd0;
    end
  end

  // Store phase sequencing
  always_comb begin
    phaseNext = phase;
    timerCtl  = '0;
    case (phase)
      PH_IDLE: if (startReq) begin
        phaseNext = PH_ERASE;
        timerCtl.loadErase = 1'b1;
      end
      PH_ERASE: if (cntZero) begin
        phaseNext = PH_PROG;
        timerCtl.loadProg = 1'b1;
      end else timerCtl.tick = 1'b1;
      PH_PROG: if (cntZero) phaseNext = PH_IDLE;
               else timerCtl.tick = 1'b1;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      stepIdx <= 3'd0;
    end else begin
      phase   <= phaseNext;
      stepIdx <= stepNext;
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign inErase = (phase == PH_ERASE);
  assign inProg  = (phase == PH_PROG);
  assign doneNow = inProg && cntZero;

  AST_START_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && accCeCtl && keyHit && stepIdx == 3'd5 && !busy)
    |=> (busy && inErase)) else $error("store did not start"); // R1
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && !busy) |=> (stepIdx == 3'd0)) else $error("write kept step"); // R5
  AST_NONCE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accCeCtl && !busy) |=> (stepIdx == 3'd0)) else $error("non-ce read kept step"); // R7
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(inErase && inProg)) else $error("phases overlap"); // R2
  AST_ERASE_TO_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (inErase && cntZero) |=> inProg) else $error("erase not followed by program"); // R2
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    doneNow |=> !busy) else $error("busy after done"); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !doneNow) |=> busy) else $error("busy dropped early"); // R3
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (stepIdx == 3'd0)) else $error("step moved while busy"); // R9
endmodule

// File: rtl/store_key_detector.sv
module store_key_detector #(
  parameter int ADDR_W       = 13,
  parameter int ERASE_CYCLES = 16,
  parameter int PROG_CYCLES  = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accCeCtl,
  input  logic [ADDR_W-1:0] accAddr,
  output logic              arrayRdStb,
  output logic              arrayWrStb,
  output logic              memDisable,
  output logic              storeBusy,
  output logic              erasePhase,
  output logic              programPhase,
  output logic              storeDone,
  output logic [2:0]        keyStep
);
  import store_key_pkg::*;

  timer_ctl_t timerCtl;
  logic keyHit, firstHit, cntZero;

  store_key_control u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accCeCtl(accCeCtl), .keyHit(keyHit), .firstHit(firstHit), .cntZero(cntZero),
    .timerCtl(timerCtl), .stepIdx(keyStep), .busy(storeBusy),
    .inErase(erasePhase), .inProg(programPhase), .doneNow(storeDone)
  );

  store_key_datapath #(
    .ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE_CYCLES), .PROG_CYCLES(PROG_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .stepIdx(keyStep),
    .timerCtl(timerCtl), .keyHit(keyHit), .firstHit(firstHit), .cntZero(cntZero)
  );

  // Array access gating
  assign memDisable = storeBusy;
  assign arrayRdStb = accValid && !accWrite && !memDisable;
  assign arrayWrStb = accValid &&  accWrite && !memDisable;

  AST_NO_ACCESS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    storeBusy |-> (!arrayRdStb && !arrayWrStb)) else $error("access while busy"); // R8
  AST_DISABLE_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (erasePhase || programPhase) |-> memDisable) else $error("phase without disable"); // R8
endmodule

// File: tb/store_key_detector_test.sv
module store_key_detector_test;
  localparam int ADDR_W = 13;
  localparam int ERASE  = 5;
  localparam int PROG   = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accValid = 1'b0, accWrite = 1'b0, accCeCtl = 1'b0;
  logic [ADDR_W-1:0] accAddr = '0;
  logic arrayRdStb, arrayWrStb, memDisable, storeBusy;
  logic erasePhase, programPhase, storeDone;
  logic [2:0] keyStep;

  int nChecks = 0;
  int nFails  = 0;
  logic seenRd, seenWr, seenDis;

  logic [12:0] keys [6] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0, 13'h0F0F};

  always #4 clk = ~clk;

  store_key_detector #(.ADDR_W(ADDR_W), .ERASE_CYCLES(ERASE), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accCeCtl(accCeCtl), .accAddr(accAddr), .arrayRdStb(arrayRdStb),
    .arrayWrStb(arrayWrStb), .memDisable(memDisable), .storeBusy(storeBusy),
    .erasePhase(erasePhase), .programPhase(programPhase), .storeDone(storeDone),
    .keyStep(keyStep)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic access(input logic [12:0] addr, input logic wr, input logic ce);
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accCeCtl = ce; accAddr = ADDR_W'(addr);
    #1;
    seenRd = arrayRdStb; seenWr = arrayWrStb; seenDis = memDisable;
    @(negedge clk);
    accValid = 1'b0; accWrite = 1'b0; accCeCtl = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 100 && storeBusy; i++) @(negedge clk);
  endtask

  task automatic testReset();
    check("R10 busy", storeBusy, 0);
    check("R10 erase", erasePhase, 0);
    check("R10 program", programPhase, 0);
    check("R10 done", storeDone, 0);
    check("R10 step", keyStep, 0);
  endtask

  task automatic testFullStore();
    for (int i = 0; i < 6; i++) begin
      access(keys[i], 1'b0, 1'b1);
      check("R8 idle read strobe", seenRd, 1);
      if (i < 5) check("R1 step count", keyStep, i + 1);
    end
    check("R1 busy after sixth read", storeBusy, 1);
    for (int i = 0; i < ERASE; i++) begin
      check("R2 erase phase", erasePhase, 1);
      check("R2 no program in erase", programPhase, 0);
      check("R3 busy in erase", storeBusy, 1);
      @(negedge clk);
    end
    for (int i = 0; i < PROG; i++) begin
      check("R2 program phase", programPhase, 1);
      check("R2 no erase in program", erasePhase, 0);
      check("R3 done pulse", storeDone, (i == PROG - 1) ? 1 : 0);
      @(negedge clk);
    end
    check("R3 busy released", storeBusy, 0);
  endtask

  task automatic testBusyIgnore();
    for (int i = 0; i < 6; i++) access(keys[i], 1'b0, 1'b1);
    access(keys[0], 1'b0, 1'b1);
    check("R8 read blocked", seenRd, 0);
    check("R8 disable", seenDis, 1);
    access(keys[1], 1'b1, 1'b1);
    check("R8 write blocked", seenWr, 0);
    access(keys[1], 1'b0, 1'b1);
    access(keys[2], 1'b0, 1'b1);
    waitIdle();
    check("R9 step after store", keyStep, 0);
    for (int i = 3; i < 6; i++) access(keys[i], 1'b0, 1'b1);
    check("R9 no store from busy reads", storeBusy, 0);
  endtask

  task automatic testAbort();
    access(keys[0], 1'b0, 1'b1);
    access(keys[1], 1'b0, 1'b1);
    access(13'h1234, 1'b0, 1'b1);
    check("R4 abort step", keyStep, 0);
    for (int i = 2; i < 6; i++) access(keys[i], 1'b0, 1'b1);
    check("R4 no store after abort", storeBusy, 0);
  endtask

  task automatic testRearm();
    access(keys[0], 1'b0, 1'b1);
    access(keys[1], 1'b0, 1'b1);
    access(keys[0], 1'b0, 1'b1);
    check("R6 rearm step", keyStep, 1);
    for (int i = 1; i < 6; i++) access(keys[i], 1'b0, 1'b1);
    check("R6 store after rearm", storeBusy, 1);
    waitIdle();
  endtask

  task automatic testWrite();
    access(keys[0], 1'b0, 1'b1);
    access(keys[1], 1'b0, 1'b1);
    access(keys[2], 1'b1, 1'b1);
    check("R5 write reaches array", seenWr, 1);
    check("R5 write clears step", keyStep, 0);
    for (int i = 3; i < 6; i++) access(keys[i], 1'b0, 1'b1);
    check("R5 no store after write", storeBusy, 0);
  endtask

  task automatic testCeCtl();
    access(keys[0], 1'b0, 1'b1);
    access(keys[1], 1'b0, 1'b0);
    check("R7 non-ce read clears", keyStep, 0);
    access(keys[0], 1'b0, 1'b0);
    check("R7 non-ce first key no arm", keyStep, 0);
  endtask

  initial begin
    fork
      begin
        #20 rstN = 1'b1;
        @(negedge clk);
        testReset();
        testFullStore();
        testBusyIgnore();
        testAbort();
        testRearm();
        testWrite();
        testCeCtl();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule